// File: doc/BRIEF.md
# Serial FIFO Threshold Events and Flow Control

This block watches the occupancy counts of a serial port's 64-entry receive and transmit FIFOs and turns them into single-cycle event pulses for the interrupt logic. The receive-trigger event fires when the receive count climbs to a selected threshold. The transmit-request event fires when the transmit count drains to a selected threshold. A receive-timeout event fires when characters sit unread in the receive FIFO and the line has been quiet for a selected number of character times. The thresholds include 48, which is not a power of two.

The block also handles hardware handshaking. It drives an RTS pin from the receive count, with a selectable deassert threshold and a polarity option. It synchronises the incoming CTS pin and, when gating is enabled, raises a transmit-hold signal for the serial shifter. The FIFOs, the bus interface and the shifters sit outside the block. The surrounding logic supplies the two occupancy counts, a pulse for each character time, strobes for character arrival and FIFO read, and the configuration fields.

Top module: `uart_fifo_watch`

## Requirements
- R1: `rx_trig_sel_i` picks the receive threshold: codes 0,1,2,3,4,5 give 1,4,8,16,32,48 bytes, and codes 6 and 7 also give 48. `rx_trig_o` is high for exactly one cycle, in the cycle after the first clock edge at which `rx_level_i` is at or above the threshold.
- R2: The receive trigger does not fire again while the occupancy stays at or above the threshold. It re-arms only after a clock edge at which the occupancy is below the threshold.
- R3: `tx_trig_sel_i` codes 0,1,2,3 give transmit thresholds of 0 (empty), 4, 8 and 16. `tx_req_o` pulses for one cycle, in the cycle after the first edge at which `tx_level_i` is at or below the threshold, and does not repeat while the occupancy stays there.
- R4: `tmo_sel_i` code 0 disables the receive timeout. Codes 1,2,3 give 4, 8 and 16 character times. With a non-empty receive FIFO and no restart, `rx_tmo_o` pulses in the cycle after the edge that samples the N-th `char_tick_i`.
- R5: A high `rx_push_i` or `rx_pop_i`, or an empty receive FIFO, restarts the timeout count. A restart in the same cycle as a tick wins, and that tick is not counted.
- R6: The timeout fires at most once per quiet period. Further ticks do not fire it again until a restart.
- R7: With `rts_en_i` high, RTS is deasserted after an edge at which `rx_level_i` is at or above the RTS threshold, and asserted after an edge at which it is below. `rts_thr_sel_i` codes 0,1,2,3 give 8, 16, 32 and 48. With `rts_en_i` low, RTS is always asserted.
- R8: Asserted RTS drives `rts_o` high when `rts_inv_i` is low and low when `rts_inv_i` is high. The inversion acts at once, without a clock edge.
- R9: CTS passes through a synchroniser of SYNC_STAGES flops (default 2). It counts as asserted when the synchronised level is high and `cts_inv_i` is low, or low and `cts_inv_i` is high. `tx_hold_o` is high exactly when `cts_en_i` is high and synchronised CTS is not asserted.
- R10: During and after reset, before any stimulus, `rx_trig_o`, `tx_req_o` and `rx_tmo_o` are low, RTS is asserted and `tx_hold_o` is low when CTS gating is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level_i | input | LVL_W (7) | Receive FIFO occupancy |
| tx_level_i | input | LVL_W (7) | Transmit FIFO occupancy |
| char_tick_i | input | 1 | One-cycle pulse per character time |
| rx_push_i | input | 1 | Character written into receive FIFO |
| rx_pop_i | input | 1 | Character read from receive FIFO |
| rx_trig_sel_i | input | 3 | Receive trigger threshold code |
| tx_trig_sel_i | input | 2 | Transmit threshold code |
| tmo_sel_i | input | 2 | Receive timeout code |
| rts_en_i | input | 1 | Hardware RTS enable |
| rts_thr_sel_i | input | 2 | RTS deassert threshold code |
| rts_inv_i | input | 1 | RTS polarity invert |
| cts_en_i | input | 1 | CTS gating enable |
| cts_inv_i | input | 1 | CTS polarity invert |
| cts_i | input | 1 | CTS pin |
| rx_trig_o | output | 1 | Receive trigger event pulse |
| rx_tmo_o | output | 1 | Receive timeout event pulse |
| tx_req_o | output | 1 | Transmit request event pulse |
| rts_o | output | 1 | RTS pin level |
| tx_hold_o | output | 1 | Stop the transmitter |

## Verification
Two functions can land in the same cycle. The receive trigger and a timeout restart collide when the character whose arrival crosses the trigger threshold also arrives on the tick that would have completed the quiet period. The bench provokes this by holding the FIFO non-empty through three ticks and then raising `rx_level_i` to the threshold, `rx_push_i` and `char_tick_i` together in one cycle. In that cycle the trigger must pulse and the timeout must stay low. Only four further ticks may then produce the timeout, which shows that the push restarted the count and that the coincident tick was not counted.

// File: rtl/uart_fw_pkg.sv
package uart_fw_pkg;

   localparam int unsigned TMO_CNT_W = 5;

   function automatic int unsigned rx_thr_of(input logic [2:0] code);
      case (code)
         3'd0:    return 1;
         3'd1:    return 4;
         3'd2:    return 8;
         3'd3:    return 16;
         3'd4:    return 32;
         default: return 48;
      endcase
   endfunction

   function automatic int unsigned tx_thr_of(input logic [1:0] code);
      case (code)
         2'd0:    return 0;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 16;
      endcase
   endfunction

   function automatic int unsigned tmo_len_of(input logic [1:0] code);
      case (code)
         2'd0:    return 0;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 16;
      endcase
   endfunction

   function automatic int unsigned rts_thr_of(input logic [1:0] code);
      case (code)
         2'd0:    return 8;
         2'd1:    return 16;
         2'd2:    return 32;
         default: return 48;
      endcase
   endfunction

endpackage

// File: rtl/fw_level_event.sv
module fw_level_event #(
   parameter int unsigned LVL_W    = 7,
   parameter bit          AT_ABOVE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level_i,
   input  logic [LVL_W-1:0] thr_i,
   output logic             evt_o
);

   localparam logic PREV_RST = !AT_ABOVE;

   logic hit;
   logic hit_q;
   logic evt_q;

   generate
      if (AT_ABOVE) begin : g_above
         assign hit = (level_i >= thr_i);
      end else begin : g_below
         assign hit = (level_i <= thr_i);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= PREV_RST;
         evt_q <= 1'b0;
      end else begin
         hit_q <= hit;
         evt_q <= hit & ~hit_q;
      end
   end

   assign evt_o = evt_q;

endmodule

// File: rtl/fw_rx_timeout.sv
module fw_rx_timeout #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] len_i,
   input  logic             nonempty_i,
   input  logic             tick_i,
   input  logic             restart_i,
   output logic             tmo_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             fired_q;
   logic             tmo_q;
   logic             enabled;
   logic             clear;
   logic             last_tick;

   assign enabled   = (len_i != '0);
   assign clear     = !enabled || !nonempty_i || restart_i;
   assign last_tick = tick_i && !fired_q && ((cnt_q + CNT_W'(1)) == len_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
         tmo_q   <= 1'b0;
      end else if (clear) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         tmo_q <= last_tick;
         if (tick_i && !fired_q) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
         if (last_tick) begin
            fired_q <= 1'b1;
         end
      end
   end

   assign tmo_o = tmo_q;

endmodule

// File: rtl/fw_flow_ctl.sv
module fw_flow_ctl #(
   parameter int unsigned LVL_W       = 7,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] rx_level_i,
   input  logic [LVL_W-1:0] rts_thr_i,
   input  logic             rts_en_i,
   input  logic             rts_inv_i,
   input  logic             cts_i,
   input  logic             cts_en_i,
   input  logic             cts_inv_i,
   output logic             rts_o,
   output logic             tx_hold_o
);

   logic rts_act_q;
   logic cts_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts_act_q <= 1'b1;
      end else begin
         rts_act_q <= !rts_en_i || (rx_level_i < rts_thr_i);
      end
   end

   assign rts_o = rts_act_q ^ rts_inv_i;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign cts_s = cts_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q <= {sync_q[SYNC_STAGES-1:0], cts_i} >> 0;
            end
         end
         assign cts_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   assign tx_hold_o = cts_en_i && !(cts_s ^ cts_inv_i);

endmodule

// File: rtl/uart_fifo_watch.sv
module uart_fifo_watch
   import uart_fw_pkg::*;
#(
   parameter int unsigned DEPTH       = 64,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LVL_W       = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] rx_level_i,
   input  logic [LVL_W-1:0] tx_level_i,
   input  logic             char_tick_i,
   input  logic             rx_push_i,
   input  logic             rx_pop_i,
   input  logic [2:0]       rx_trig_sel_i,
   input  logic [1:0]       tx_trig_sel_i,
   input  logic [1:0]       tmo_sel_i,
   input  logic             rts_en_i,
   input  logic [1:0]       rts_thr_sel_i,
   input  logic             rts_inv_i,
   input  logic             cts_en_i,
   input  logic             cts_inv_i,
   input  logic             cts_i,
   output logic             rx_trig_o,
   output logic             rx_tmo_o,
   output logic             tx_req_o,
   output logic             rts_o,
   output logic             tx_hold_o
);

   localparam int unsigned MAX_THR = 48;

   if (DEPTH < MAX_THR) begin : g_depth_chk
      $error("uart_fifo_watch: DEPTH must cover the largest threshold");
   end
   if (LVL_W < $clog2(DEPTH + 1)) begin : g_width_chk
      $error("uart_fifo_watch: LVL_W too narrow for DEPTH");
   end
   if (SYNC_STAGES > 4) begin : g_sync_chk
      $error("uart_fifo_watch: SYNC_STAGES out of range");
   end

   logic [LVL_W-1:0]     rx_thr;
   logic [LVL_W-1:0]     tx_thr;
   logic [LVL_W-1:0]     rts_thr;
   logic [TMO_CNT_W-1:0] tmo_len;

   assign rx_thr  = LVL_W'(rx_thr_of(rx_trig_sel_i));
   assign tx_thr  = LVL_W'(tx_thr_of(tx_trig_sel_i));
   assign rts_thr = LVL_W'(rts_thr_of(rts_thr_sel_i));
   assign tmo_len = TMO_CNT_W'(tmo_len_of(tmo_sel_i));

   fw_level_event #(.LVL_W(LVL_W), .AT_ABOVE(1'b1)) u_rx_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (rx_level_i),
      .thr_i   (rx_thr),
      .evt_o   (rx_trig_o)
   );

   fw_level_event #(.LVL_W(LVL_W), .AT_ABOVE(1'b0)) u_tx_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (tx_level_i),
      .thr_i   (tx_thr),
      .evt_o   (tx_req_o)
   );

   fw_rx_timeout #(.CNT_W(TMO_CNT_W)) u_tmo (
      .clk        (clk),
      .rst_n      (rst_n),
      .len_i      (tmo_len),
      .nonempty_i (rx_level_i != '0),
      .tick_i     (char_tick_i),
      .restart_i  (rx_push_i || rx_pop_i),
      .tmo_o      (rx_tmo_o)
   );

   fw_flow_ctl #(.LVL_W(LVL_W), .SYNC_STAGES(SYNC_STAGES)) u_flow (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_level_i (rx_level_i),
      .rts_thr_i  (rts_thr),
      .rts_en_i   (rts_en_i),
      .rts_inv_i  (rts_inv_i),
      .cts_i      (cts_i),
      .cts_en_i   (cts_en_i),
      .cts_inv_i  (cts_inv_i),
      .rts_o      (rts_o),
      .tx_hold_o  (tx_hold_o)
   );

endmodule

// File: rtl/fw_checker.sv
module fw_checker #(
   parameter int unsigned LVL_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] rx_level_i,
   input logic             rx_push_i,
   input logic             rx_pop_i,
   input logic [1:0]       tmo_sel_i,
   input logic             rts_en_i,
   input logic             rts_inv_i,
   input logic             cts_en_i,
   input logic             rx_trig_o,
   input logic             rx_tmo_o,
   input logic             tx_req_o,
   input logic             rts_o,
   input logic             tx_hold_o
);

   a_r1_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_trig_o |=> !rx_trig_o);

   a_r3_txreq_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req_o |=> !tx_req_o);

   a_r6_tmo_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_tmo_o |=> !rx_tmo_o);

   a_r4_tmo_off: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tmo_sel_i) == 2'd0) |-> !rx_tmo_o);

   a_r5_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rx_push_i) || $past(rx_pop_i)) |-> !rx_tmo_o);

   a_r5_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rx_level_i) == '0) |-> !rx_tmo_o);

   a_r7_rts_off: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rts_en_i) |-> (rts_o == !rts_inv_i));

   a_r9_cts_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cts_en_i |-> !tx_hold_o);

endmodule

bind uart_fifo_watch fw_checker #(.LVL_W(LVL_W)) u_fw_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_level_i (rx_level_i),
   .rx_push_i  (rx_push_i),
   .rx_pop_i   (rx_pop_i),
   .tmo_sel_i  (tmo_sel_i),
   .rts_en_i   (rts_en_i),
   .rts_inv_i  (rts_inv_i),
   .cts_en_i   (cts_en_i),
   .rx_trig_o  (rx_trig_o),
   .rx_tmo_o   (rx_tmo_o),
   .tx_req_o   (tx_req_o),
   .rts_o      (rts_o),
   .tx_hold_o  (tx_hold_o)
);

// File: tb/tb_uart_fifo_watch.sv
`timescale 1ns/1ps
module tb_uart_fifo_watch;

   localparam int LW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [LW-1:0] rx_level = '0;
   logic [LW-1:0] tx_level = '0;
   logic          tick = 1'b0, push = 1'b0, pop = 1'b0;
   logic [2:0]    rx_sel = '0;
   logic [1:0]    tx_sel = '0, tmo_sel = '0, rts_sel = '0;
   logic          rts_en = 1'b0, rts_inv = 1'b0;
   logic          cts_en = 1'b0, cts_inv = 1'b0, cts = 1'b0;
   logic          rx_trig, rx_tmo, tx_req, rts, tx_hold;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   uart_fifo_watch dut (
      .clk (clk), .rst_n (rst_n),
      .rx_level_i (rx_level), .tx_level_i (tx_level),
      .char_tick_i (tick), .rx_push_i (push), .rx_pop_i (pop),
      .rx_trig_sel_i (rx_sel), .tx_trig_sel_i (tx_sel), .tmo_sel_i (tmo_sel),
      .rts_en_i (rts_en), .rts_thr_sel_i (rts_sel), .rts_inv_i (rts_inv),
      .cts_en_i (cts_en), .cts_inv_i (cts_inv), .cts_i (cts),
      .rx_trig_o (rx_trig), .rx_tmo_o (rx_tmo), .tx_req_o (tx_req),
      .rts_o (rts), .tx_hold_o (tx_hold)
   );

   // vector: [11] 0=receive 1=transmit, [10:8] code, [5:0] expected threshold
   localparam logic [11:0] VEC [0:11] = '{
      {1'b0, 3'd0, 2'b0, 6'd1},  {1'b0, 3'd1, 2'b0, 6'd4},
      {1'b0, 3'd2, 2'b0, 6'd8},  {1'b0, 3'd3, 2'b0, 6'd16},
      {1'b0, 3'd4, 2'b0, 6'd32}, {1'b0, 3'd5, 2'b0, 6'd48},
      {1'b0, 3'd6, 2'b0, 6'd48}, {1'b0, 3'd7, 2'b0, 6'd48},
      {1'b1, 3'd0, 2'b0, 6'd0},  {1'b1, 3'd1, 2'b0, 6'd4},
      {1'b1, 3'd2, 2'b0, 6'd8},  {1'b1, 3'd3, 2'b0, 6'd16}
   };

   task automatic chk(input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic tick_n(input int n, input string what, input logic last_exp);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         step();
         tick = 1'b0;
         chk(what, rx_tmo, (i == n - 1) ? last_exp : 1'b0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) step();
      chk("R10 reset rx_trig", rx_trig, 1'b0);
      chk("R10 reset rx_tmo", rx_tmo, 1'b0);
      chk("R10 reset tx_req", tx_req, 1'b0);
      chk("R10 reset rts", rts, 1'b1);
      chk("R10 reset tx_hold", tx_hold, 1'b0);
      rst_n = 1'b1;
      tx_level = 7'd20;
      step();
      step();
      chk("R10 idle after reset rx_trig", rx_trig, 1'b0);

      // table walk: threshold decoding of both event paths
      for (int v = 0; v < 12; v++) begin
         logic [LW-1:0] t;
         t = LW'(VEC[v][5:0]);
         if (!VEC[v][11]) begin
            rx_sel = VEC[v][10:8];
            rx_level = '0;
            step();
            rx_level = t - 1'b1;
            step();
            chk($sformatf("R1 rx code %0d below", VEC[v][10:8]), rx_trig, 1'b0);
            rx_level = t;
            step();
            chk($sformatf("R1 rx code %0d reach", VEC[v][10:8]), rx_trig, 1'b1);
            rx_level = t + 1'b1;
            step();
            chk($sformatf("R2 rx code %0d hold", VEC[v][10:8]), rx_trig, 1'b0);
            rx_level = '0;
            step();
         end else begin
            tx_sel = VEC[v][9:8];
            tx_level = 7'd20;
            step();
            tx_level = t + 1'b1;
            step();
            chk($sformatf("R3 tx code %0d above", VEC[v][9:8]), tx_req, 1'b0);
            tx_level = t;
            step();
            chk($sformatf("R3 tx code %0d reach", VEC[v][9:8]), tx_req, 1'b1);
            step();
            chk($sformatf("R3 tx code %0d hold", VEC[v][9:8]), tx_req, 1'b0);
         end
      end

      // R2: re-arm only after dropping below
      rx_sel = 3'd2;
      rx_level = 7'd9;
      step();
      chk("R2 rearm first", rx_trig, 1'b1);
      rx_level = 7'd7;
      step();
      rx_level = 7'd8;
      step();
      chk("R2 rearm second", rx_trig, 1'b1);
      rx_level = '0;
      step();

      // timeout: 4 character times, single shot, restart by pop
      tmo_sel = 2'd1;
      rx_level = 7'd3;
      step();
      tick_n(4, "R4 tmo len4", 1'b1);
      tick_n(6, "R6 tmo no repeat", 1'b0);
      pop = 1'b1;
      step();
      pop = 1'b0;
      tick_n(4, "R5 tmo after pop", 1'b1);
      tmo_sel = 2'd2;
      push = 1'b1;
      step();
      push = 1'b0;
      tick_n(8, "R4 tmo len8", 1'b1);
      tmo_sel = 2'd3;
      pop = 1'b1;
      step();
      pop = 1'b0;
      tick_n(16, "R4 tmo len16", 1'b1);
      tmo_sel = 2'd0;
      pop = 1'b1;
      step();
      pop = 1'b0;
      tick_n(20, "R4 tmo disabled", 1'b0);
      tmo_sel = 2'd1;
      rx_level = '0;
      step();
      tick_n(10, "R5 tmo empty fifo", 1'b0);

      // coincidence: trigger crossing with push on the would-be last tick
      rx_sel = 3'd1;
      rx_level = 7'd2;
      step();
      tick_n(3, "R5 coincide lead", 1'b0);
      rx_level = 7'd4;
      push = 1'b1;
      tick = 1'b1;
      step();
      push = 1'b0;
      tick = 1'b0;
      chk("R1 coincide trigger", rx_trig, 1'b1);
      chk("R5 coincide no tmo", rx_tmo, 1'b0);
      tick_n(4, "R5 coincide restart", 1'b1);
      tmo_sel = 2'd0;
      rx_level = '0;
      step();

      // RTS
      rts_en = 1'b1;
      rts_sel = 2'd0;
      rx_level = 7'd7;
      step();
      chk("R7 rts below 8", rts, 1'b1);
      rx_level = 7'd8;
      step();
      chk("R7 rts at 8", rts, 1'b0);
      rts_inv = 1'b1;
      #1;
      chk("R8 rts inverted", rts, 1'b1);
      rts_inv = 1'b0;
      rx_level = 7'd7;
      step();
      chk("R7 rts back below", rts, 1'b1);
      rts_sel = 2'd3;
      rx_level = 7'd47;
      step();
      chk("R7 rts below 48", rts, 1'b1);
      rx_level = 7'd48;
      step();
      chk("R7 rts at 48", rts, 1'b0);
      rts_en = 1'b0;
      rx_level = 7'd60;
      step();
      chk("R7 rts disabled", rts, 1'b1);
      rts_inv = 1'b1;
      #1;
      chk("R8 rts disabled inverted", rts, 1'b0);
      rts_inv = 1'b0;
      rx_level = '0;
      step();

      // CTS
      cts_en = 1'b1;
      cts = 1'b1;
      repeat (3) step();
      chk("R9 cts asserted", tx_hold, 1'b0);
      cts = 1'b0;
      step();
      chk("R9 cts one stage", tx_hold, 1'b0);
      step();
      chk("R9 cts two stages", tx_hold, 1'b1);
      cts_inv = 1'b1;
      #1;
      chk("R9 cts inverted", tx_hold, 1'b0);
      cts_inv = 1'b0;
      cts_en = 1'b0;
      #1;
      chk("R9 cts gating off", tx_hold, 1'b0);
      step();

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule